// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block drives one transmit packet DMA channel through a ring of descriptors. It reads one descriptor at a time from a descriptor port, checks the start-of-packet flag and the options field against the packet boundary it has predicted, and issues one data request per accepted descriptor towards the transmit interface. The packet length carried in the first descriptor of a packet, together with each descriptor's buffer length, tells the block which descriptor must open the next packet. When a packet completes, the block can write the first descriptor back with its start-of-packet flag cleared, so software can see that transmission finished.

Software hands descriptors over by adding a signed increment to a credit count. The block takes one credit for each descriptor it consumes. A mismatch between a descriptor and the expected boundary halts the channel with a sticky error. The error clears only when the channel is disabled and enabled again, and re-enabling restarts the walk at ring slot 0. Between packets, a software pause or a selected flow-control pause request holds the channel. A packet already in flight always runs to its end.

The descriptor word is `{sop, opts[OPT_W], pkt_len[LEN_W], buf_len[LEN_W]}`, with `sop` as the most significant bit and `buf_len` in the lowest bits.

Top module: `txd_ring_walker`

## Requirements
- R1: After reset the credit count is 0, and `desc_err`, `desc_rd_req`, `dreq_vld` and `desc_wr_en` are all low.
- R2: A descriptor read (`desc_rd_req`, a one-cycle pulse) is issued only while the channel is enabled and the credit count is nonzero. Each accepted descriptor decrements the count by one.
- R3: `cnt_add_val` is added modulo 2^CNT_W to the count in the cycle `cnt_add_vld` is high, so writing the two's complement of the count clears it.
- R4: A packet ends on the descriptor whose `buf_len` is at least the remaining length (initially `pkt_len` of the opening descriptor, then reduced by each `buf_len`). The next descriptor is expected to have `sop`=1.
- R5: A descriptor with `sop`=0 where a packet must start sets `desc_err` and stops the walk, and consumes no credit.
- R6: `sop`=1 with `opts`=0, `sop`=0 with `opts`≠0, or `sop`=1 inside a packet is a descriptor error.
- R7: Each accepted descriptor yields one single-cycle `dreq_vld`, one cycle after its read data, carrying its `buf_len`, `opts`, whether it opens the packet (`dreq_sop`) and whether it ends it (`dreq_eop`).
- R8: With `cfg_wb_en`=1, a completed packet writes its opening descriptor back to that slot in the same cycle as the final `dreq_vld`, with `sop` cleared and all other bits unchanged. With `cfg_wb_en`=0 nothing is written.
- R9: While `chan_en` is low the slot pointer returns to 0 and the credit count is kept. The first read after enabling is from slot 0.
- R10: With `cfg_pause`=1 no new packet is started. A packet already begun finishes, and clearing the bit resumes the walk.
- R11: A new packet is also held when `cfg_fc_en`, `cfg_fc_sel` and `fc_req` are all 1. If either enable is 0, `fc_req` has no effect.
- R12: `desc_err` stays high, and no reads are issued, until `chan_en` is lowered. Lowering it clears the error.
- R13: The slot pointer advances by one per accepted descriptor and wraps from RING_DEPTH-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_en | input | 1 | Channel enable; low restarts at slot 0 and clears error |
| cfg_wb_en | input | 1 | Enable status writeback at packet end |
| cfg_pause | input | 1 | Software pause at packet boundary |
| cfg_fc_en | input | 1 | Channel-level flow control enable |
| cfg_fc_sel | input | 1 | This channel obeys flow-control pause |
| fc_req | input | 1 | Pause request from received pause frames |
| cnt_add_vld | input | 1 | Apply credit increment |
| cnt_add_val | input | CNT_W | Signed credit increment |
| desc_cnt | output | CNT_W | Current credit count |
| desc_rd_req | output | 1 | Descriptor read request pulse |
| desc_rd_idx | output | IDX_W | Slot to read |
| desc_rd_vld | input | 1 | Read data valid |
| desc_rd_word | input | DW | Descriptor read data |
| desc_wr_en | output | 1 | Status writeback strobe |
| desc_wr_idx | output | IDX_W | Slot written back |
| desc_wr_word | output | DW | Written-back descriptor |
| dreq_vld | output | 1 | Data request strobe |
| dreq_len | output | LEN_W | Buffer length of the request |
| dreq_opts | output | OPT_W | Options of the descriptor |
| dreq_sop | output | 1 | Request opens a packet |
| dreq_eop | output | 1 | Request closes a packet |
| desc_err | output | 1 | Sticky descriptor error |

## Verification
The bench builds the walker with an 8-slot ring, 8-bit credit and length fields and 4-bit options, with writeback present. With eight slots, one pass through a mixed ring of single- and multi-buffer packets reaches the wrap back to slot 0, and the slot written back on that pass then comes round as a cleared start flag. With 8-bit credit, a two's-complement clear is a single-byte add. The narrow length field keeps remaining-length arithmetic easy to follow, including a zero-length packet and a buffer longer than what remains.

// File: rtl/txd_pkg.sv
package txd_pkg;
   typedef enum logic [1:0] {
      TXD_IDLE = 2'd0,
      TXD_WAIT = 2'd1,
      TXD_HALT = 2'd2
   } txd_state_e;
endpackage

// File: rtl/txd_rule.sv
// Boundary and field rules for one descriptor against the predicted packet position.
module txd_rule #(
   parameter int OPT_W = 4,
   parameter int LEN_W = 8,
   parameter int DW    = 1 + OPT_W + 2 * LEN_W
) (
   input  logic [DW-1:0]    word,
   input  logic             expect_sop,
   input  logic [LEN_W-1:0] rem,
   output logic             bad,
   output logic             eop,
   output logic [LEN_W-1:0] rem_next
);
   localparam int PKT_LSB = LEN_W;
   localparam int OPT_LSB = 2 * LEN_W;
   localparam int SOP_BIT = DW - 1;

   logic             sop;
   logic [OPT_W-1:0] opts;
   logic [LEN_W-1:0] pkt_len;
   logic [LEN_W-1:0] buf_len;
   logic [LEN_W-1:0] base;

   always_comb begin
      sop      = word[SOP_BIT];
      opts     = word[OPT_LSB +: OPT_W];
      pkt_len  = word[PKT_LSB +: LEN_W];
      buf_len  = word[LEN_W-1:0];
      base     = expect_sop ? pkt_len : rem;
      bad      = (sop != expect_sop) || (sop && (opts == '0)) || (!sop && (opts != '0));
      eop      = (buf_len >= base);
      rem_next = base - buf_len;
   end
endmodule

// File: rtl/txd_credit.sv
// Descriptor credit count: signed software increment, one decrement per consumed descriptor.
module txd_credit #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             add_vld,
   input  logic [CNT_W-1:0] add_val,
   input  logic             dec,
   output logic [CNT_W-1:0] cnt
);
   logic [CNT_W-1:0] add_term;

   assign add_term = add_vld ? add_val : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt + add_term - {{(CNT_W-1){1'b0}}, dec};
   end

   // R3: adding the negation of the count empties it
   p_neg_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (add_vld && !dec && (add_val == (~cnt + 1'b1))) |=> (cnt == '0));

   // R2: a consumed descriptor takes exactly one credit
   p_dec_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!add_vld && dec) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/txd_ring_walker.sv
module txd_ring_walker
   import txd_pkg::*;
#(
   parameter int RING_DEPTH = 8,
   parameter int CNT_W      = 8,
   parameter int LEN_W      = 8,
   parameter int OPT_W      = 4,
   parameter bit WB_SUPPORT = 1'b1,
   localparam int IDX_W     = (RING_DEPTH > 1) ? $clog2(RING_DEPTH) : 1,
   localparam int DW        = 1 + OPT_W + 2 * LEN_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             chan_en,
   input  logic             cfg_wb_en,
   input  logic             cfg_pause,
   input  logic             cfg_fc_en,
   input  logic             cfg_fc_sel,
   input  logic             fc_req,
   input  logic             cnt_add_vld,
   input  logic [CNT_W-1:0] cnt_add_val,
   output logic [CNT_W-1:0] desc_cnt,
   output logic             desc_rd_req,
   output logic [IDX_W-1:0] desc_rd_idx,
   input  logic             desc_rd_vld,
   input  logic [DW-1:0]    desc_rd_word,
   output logic             desc_wr_en,
   output logic [IDX_W-1:0] desc_wr_idx,
   output logic [DW-1:0]    desc_wr_word,
   output logic             dreq_vld,
   output logic [LEN_W-1:0] dreq_len,
   output logic [OPT_W-1:0] dreq_opts,
   output logic             dreq_sop,
   output logic             dreq_eop,
   output logic             desc_err
);
   localparam int SOP_BIT = DW - 1;
   localparam int OPT_LSB = 2 * LEN_W;

   if (RING_DEPTH < 2) begin : g_bad_depth
      $error("RING_DEPTH must be at least 2");
   end
   if (CNT_W < IDX_W) begin : g_bad_cnt
      $error("CNT_W must cover the ring depth");
   end
   if (LEN_W < 1 || OPT_W < 1) begin : g_bad_fields
      $error("LEN_W and OPT_W must be positive");
   end

   txd_state_e       state;
   logic [IDX_W-1:0] idx, idx_nxt, sop_idx;
   logic [DW-1:0]    sop_word;
   logic             at_bnd;
   logic [LEN_W-1:0] rem;
   logic             chk_bad, chk_eop;
   logic [LEN_W-1:0] chk_rem;
   logic             hold, accept, wb_on;
   logic [DW-1:0]    wb_src;

   // Slot pointer wrap: free-running when the depth fills the index, compared otherwise
   if ((1 << IDX_W) == RING_DEPTH) begin : g_wrap_pow2
      assign idx_nxt = idx + 1'b1;
   end else begin : g_wrap_cmp
      assign idx_nxt = (idx == IDX_W'(RING_DEPTH - 1)) ? '0 : idx + 1'b1;
   end

   if (WB_SUPPORT) begin : g_wb
      assign wb_on = cfg_wb_en;
   end else begin : g_no_wb
      assign wb_on = 1'b0;
   end

   txd_rule #(.OPT_W(OPT_W), .LEN_W(LEN_W), .DW(DW)) u_rule (
      .word       (desc_rd_word),
      .expect_sop (at_bnd),
      .rem        (rem),
      .bad        (chk_bad),
      .eop        (chk_eop),
      .rem_next   (chk_rem)
   );

   assign accept = chan_en && (state == TXD_WAIT) && desc_rd_vld && !chk_bad;
   assign hold   = cfg_pause || (cfg_fc_en && cfg_fc_sel && fc_req);
   assign wb_src = at_bnd ? desc_rd_word : sop_word;
   assign desc_rd_idx = idx;

   txd_credit #(.CNT_W(CNT_W)) u_credit (
      .clk     (clk),
      .rst_n   (rst_n),
      .add_vld (cnt_add_vld),
      .add_val (cnt_add_val),
      .dec     (accept),
      .cnt     (desc_cnt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state        <= TXD_IDLE;
         idx          <= '0;
         sop_idx      <= '0;
         sop_word     <= '0;
         at_bnd       <= 1'b1;
         rem          <= '0;
         desc_err     <= 1'b0;
         desc_rd_req  <= 1'b0;
         desc_wr_en   <= 1'b0;
         desc_wr_idx  <= '0;
         desc_wr_word <= '0;
         dreq_vld     <= 1'b0;
         dreq_len     <= '0;
         dreq_opts    <= '0;
         dreq_sop     <= 1'b0;
         dreq_eop     <= 1'b0;
      end else begin
         desc_rd_req <= 1'b0;
         desc_wr_en  <= 1'b0;
         dreq_vld    <= 1'b0;
         if (!chan_en) begin
            state    <= TXD_IDLE;
            idx      <= '0;
            at_bnd   <= 1'b1;
            desc_err <= 1'b0;
         end else begin
            unique case (state)
               TXD_IDLE: begin
                  if ((desc_cnt != '0) && !(at_bnd && hold)) begin
                     desc_rd_req <= 1'b1;
                     state       <= TXD_WAIT;
                  end
               end
               TXD_WAIT: begin
                  if (desc_rd_vld) begin
                     if (chk_bad) begin
                        desc_err <= 1'b1;
                        state    <= TXD_HALT;
                     end else begin
                        dreq_vld  <= 1'b1;
                        dreq_len  <= desc_rd_word[LEN_W-1:0];
                        dreq_opts <= desc_rd_word[OPT_LSB +: OPT_W];
                        dreq_sop  <= at_bnd;
                        dreq_eop  <= chk_eop;
                        if (at_bnd) begin
                           sop_idx  <= idx;
                           sop_word <= desc_rd_word;
                        end
                        if (chk_eop && wb_on) begin
                           desc_wr_en   <= 1'b1;
                           desc_wr_idx  <= at_bnd ? idx : sop_idx;
                           desc_wr_word <= {1'b0, wb_src[DW-2:0]};
                        end
                        rem    <= chk_rem;
                        at_bnd <= chk_eop;
                        idx    <= idx_nxt;
                        state  <= TXD_IDLE;
                     end
                  end
               end
               default: state <= TXD_HALT;
            endcase
         end
      end
   end

   // R12: error holds while the channel stays enabled
   p_err_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (desc_err && chan_en) |=> desc_err);

   // R12: a halted channel issues no reads
   p_err_no_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
      desc_err |-> !desc_rd_req);

   // R2: reads only against a nonzero credit count
   p_read_credit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      desc_rd_req |-> ($past(desc_cnt) != '0));

   // R7: data requests are single-cycle strobes
   p_dreq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      dreq_vld |=> !dreq_vld);

   // R8: writeback coincides with the closing data request
   p_wb_with_eop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      desc_wr_en |-> (dreq_vld && dreq_eop));

   // R8: written-back word has its start flag cleared
   p_wb_sop_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      desc_wr_en |-> !desc_wr_word[SOP_BIT]);

   // R10: after a packet closes under pause, no new read starts
   p_pause_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (dreq_vld && dreq_eop && cfg_pause) |=> !desc_rd_req);
endmodule

// File: tb/txd_ring_walker_tb.sv
module txd_ring_walker_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int RD    = 8;
   localparam int CNT_W = 8;
   localparam int LEN_W = 8;
   localparam int OPT_W = 4;
   localparam int IDX_W = 3;
   localparam int DW    = 1 + OPT_W + 2 * LEN_W;
   localparam int CMASK = (1 << CNT_W) - 1;
   localparam int LMASK = (1 << LEN_W) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic chan_en = 1'b0, cfg_wb_en = 1'b1, cfg_pause = 1'b0;
   logic cfg_fc_en = 1'b0, cfg_fc_sel = 1'b0, fc_req = 1'b0;
   logic cnt_add_vld = 1'b0;
   logic [CNT_W-1:0] cnt_add_val = '0;
   logic [CNT_W-1:0] desc_cnt;
   logic desc_rd_req, desc_rd_vld = 1'b0;
   logic [IDX_W-1:0] desc_rd_idx, desc_wr_idx;
   logic [DW-1:0] desc_rd_word = '0, desc_wr_word;
   logic desc_wr_en, dreq_vld, dreq_sop, dreq_eop, desc_err;
   logic [LEN_W-1:0] dreq_len;
   logic [OPT_W-1:0] dreq_opts;

   always #(CLK_PERIOD/2) clk = ~clk;

   txd_ring_walker #(.RING_DEPTH(RD), .CNT_W(CNT_W), .LEN_W(LEN_W), .OPT_W(OPT_W),
                     .WB_SUPPORT(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .cfg_wb_en(cfg_wb_en),
      .cfg_pause(cfg_pause), .cfg_fc_en(cfg_fc_en), .cfg_fc_sel(cfg_fc_sel),
      .fc_req(fc_req), .cnt_add_vld(cnt_add_vld), .cnt_add_val(cnt_add_val),
      .desc_cnt(desc_cnt), .desc_rd_req(desc_rd_req), .desc_rd_idx(desc_rd_idx),
      .desc_rd_vld(desc_rd_vld), .desc_rd_word(desc_rd_word),
      .desc_wr_en(desc_wr_en), .desc_wr_idx(desc_wr_idx), .desc_wr_word(desc_wr_word),
      .dreq_vld(dreq_vld), .dreq_len(dreq_len), .dreq_opts(dreq_opts),
      .dreq_sop(dreq_sop), .dreq_eop(dreq_eop), .desc_err(desc_err));

   int checks = 0, fails = 0;
   bit done = 1'b0;
   logic [DW-1:0] mem [RD];
   int n_rd = 0, n_dv = 0, n_eop = 0, n_wr = 0, last_idx = -1;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [DW-1:0] mk(input bit sop, input int opt, input int pl, input int bl);
      return {sop, OPT_W'(opt), LEN_W'(pl), LEN_W'(bl)};
   endfunction

   // Behavioural reference: state 0 idle, 1 awaiting data, 2 halted
   int ms = 0, mi = 0, mc = 0, mrem = 0, msi = 0;
   bit mb = 1'b1;
   logic [DW-1:0] msw = '0;
   bit e_req = 0, e_dv = 0, e_wr = 0, e_err = 0, e_sop = 0, e_eop = 0;
   int e_ridx = 0, e_len = 0, e_opt = 0, e_widx = 0;
   logic [DW-1:0] e_wword = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         ms = 0; mi = 0; mc = 0; mrem = 0; mb = 1;
         e_req = 0; e_dv = 0; e_wr = 0; e_err = 0;
      end else begin
         int dec;
         dec = 0; e_req = 0; e_dv = 0; e_wr = 0;
         if (!chan_en) begin
            ms = 0; mi = 0; mb = 1; e_err = 0;
         end else if (ms == 0) begin
            bit hold;
            hold = cfg_pause || (cfg_fc_en && cfg_fc_sel && fc_req);
            if (mc != 0 && !(mb && hold)) begin e_req = 1; e_ridx = mi; ms = 1; end
         end else if (ms == 1 && desc_rd_vld) begin
            bit s; int o, pl, bl, base;
            s  = desc_rd_word[DW-1];
            o  = int'(desc_rd_word[2*LEN_W +: OPT_W]);
            pl = int'(desc_rd_word[LEN_W +: LEN_W]);
            bl = int'(desc_rd_word[LEN_W-1:0]);
            if ((s != mb) || (s && o == 0) || (!s && o != 0)) begin
               e_err = 1; ms = 2;
            end else begin
               base = mb ? pl : mrem;
               e_dv = 1; e_len = bl; e_opt = o; e_sop = mb; e_eop = (bl >= base);
               if (mb) begin msi = mi; msw = desc_rd_word; end
               if (e_eop && cfg_wb_en) begin
                  e_wr = 1; e_widx = msi; e_wword = msw; e_wword[DW-1] = 1'b0;
               end
               mrem = (base - bl) & LMASK;
               mb = e_eop;
               mi = (mi + 1) % RD;
               dec = 1; ms = 0;
            end
         end
         mc = (mc + (cnt_add_vld ? int'(cnt_add_val) : 0) - dec) & CMASK;
      end
   end

   // Memory responder, activity counters and per-cycle comparison
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R3 count", desc_cnt, mc);
         chk("R2 read request", desc_rd_req, e_req);
         if (e_req) chk("R13 read slot", desc_rd_idx, e_ridx);
         chk("R7 data request", dreq_vld, e_dv);
         if (e_dv) begin
            chk("R7 length", dreq_len, e_len);
            chk("R7 options", dreq_opts, e_opt);
            chk("R7 sop", dreq_sop, e_sop);
            chk("R4 eop", dreq_eop, e_eop);
         end
         chk("R8 writeback", desc_wr_en, e_wr);
         if (e_wr) begin
            chk("R8 writeback slot", desc_wr_idx, e_widx);
            chk("R8 writeback word", desc_wr_word, e_wword);
         end
         chk("R5 error flag", desc_err, e_err);
      end
      if (desc_wr_en) mem[desc_wr_idx] = desc_wr_word;
      if (desc_rd_req) begin
         desc_rd_vld  = 1'b1;
         desc_rd_word = mem[desc_rd_idx];
         n_rd++; last_idx = int'(desc_rd_idx);
      end else begin
         desc_rd_vld = 1'b0;
      end
      if (dreq_vld) n_dv++;
      if (dreq_vld && dreq_eop) n_eop++;
      if (desc_wr_en) n_wr++;
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic add(input int n);
      cnt_add_vld = 1'b1; cnt_add_val = CNT_W'(n);
      tick(1);
      cnt_add_vld = 1'b0;
   endtask

   task automatic restart();
      chan_en = 1'b0;
      tick(2);
      cnt_add_vld = 1'b1; cnt_add_val = ~desc_cnt + 1'b1;
      tick(1);
      cnt_add_vld = 1'b0;
      chk("R3 two's complement clear", desc_cnt, 0);
      chan_en = 1'b1;
      tick(1);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int r0, r1, r2;
      for (int i = 0; i < RD; i++) mem[i] = '0;
      tick(3);
      rst_n = 1'b1;
      tick(1);
      chk("R1 reset count", desc_cnt, 0);
      chk("R1 reset error", desc_err, 0);
      chk("R1 reset read", desc_rd_req, 0);
      chk("R1 reset data", dreq_vld, 0);

      // Mixed ring: two-buffer, single, three-buffer, oversize buffer, zero length
      mem[0] = mk(1, 3, 100, 40); mem[1] = mk(0, 0, 0, 60);
      mem[2] = mk(1, 1, 10, 10);
      mem[3] = mk(1, 5, 50, 20);  mem[4] = mk(0, 0, 0, 20); mem[5] = mk(0, 0, 0, 20);
      mem[6] = mk(1, 2, 5, 8);
      mem[7] = mk(1, 7, 0, 0);
      cfg_wb_en = 1'b1; chan_en = 1'b1;
      add(8);
      tick(30);
      chk("R7 accepted count", n_dv, 8);
      chk("R4 packets closed", n_eop, 5);
      chk("R8 writebacks", n_wr, 5);
      chk("R2 credits used", desc_cnt, 0);
      // Slot 0 was written back with its start flag cleared; wrap reaches it
      add(1);
      tick(6);
      chk("R13 wrap to slot 0", last_idx, 0);
      chk("R5 cleared start flag halts", desc_err, 1);
      r0 = n_rd;
      tick(10);
      chk("R12 no reads while halted", n_rd, r0);
      chk("R12 error held", desc_err, 1);
      chk("R5 no credit taken", desc_cnt, 1);

      chan_en = 1'b0;
      tick(2);
      chk("R9 count kept while disabled", desc_cnt, 1);
      chk("R12 disable clears error", desc_err, 0);
      restart();
      r0 = n_rd;
      tick(6);
      chk("R2 no read without credit", n_rd, r0);

      // Writeback disabled
      mem[0] = mk(1, 1, 4, 4);
      cfg_wb_en = 1'b0;
      r0 = n_wr; r1 = n_dv;
      add(1);
      tick(6);
      chk("R8 writeback suppressed", n_wr, r0);
      chk("R9 restart at slot 0", last_idx, 0);
      chk("R7 one request", n_dv - r1, 1);
      cfg_wb_en = 1'b1;

      // Pause raised mid-packet
      restart();
      mem[0] = mk(1, 2, 30, 10); mem[1] = mk(0, 0, 0, 10); mem[2] = mk(0, 0, 0, 10);
      mem[3] = mk(1, 4, 1, 1);
      add(1);
      tick(6);
      cfg_pause = 1'b1;
      r0 = n_rd; r1 = n_eop;
      add(3);
      tick(20);
      chk("R10 packet in flight completes", n_rd - r0, 2);
      chk("R10 closing request seen", n_eop - r1, 1);
      cfg_pause = 1'b0;
      tick(6);
      chk("R10 resume after clear", n_rd - r0, 3);

      // Flow control gating
      restart();
      for (int i = 0; i < 4; i++) mem[i] = mk(1, 1, 2, 2);
      cfg_fc_en = 1'b1; cfg_fc_sel = 1'b0; fc_req = 1'b1;
      r2 = n_rd;
      add(1);
      tick(6);
      chk("R11 unselected channel runs", n_rd - r2, 1);
      cfg_fc_sel = 1'b1;
      add(1);
      tick(20);
      chk("R11 selected channel held", n_rd - r2, 1);
      fc_req = 1'b0;
      tick(6);
      chk("R11 release on request drop", n_rd - r2, 2);
      fc_req = 1'b1; cfg_fc_en = 1'b0;
      add(1);
      tick(6);
      chk("R11 global enable off ignores request", n_rd - r2, 3);
      fc_req = 1'b0; cfg_fc_sel = 1'b0;

      // Field rule violations
      restart();
      mem[0] = mk(1, 0, 1, 1);
      add(1);
      tick(6);
      chk("R6 start with zero options", desc_err, 1);
      restart();
      mem[0] = mk(1, 1, 20, 5); mem[1] = mk(0, 2, 0, 5);
      r0 = n_dv;
      add(2);
      tick(8);
      chk("R6 continuation with options", desc_err, 1);
      chk("R6 first buffer accepted", n_dv - r0, 1);
      restart();
      mem[0] = mk(1, 1, 20, 5); mem[1] = mk(1, 1, 5, 5);
      add(2);
      tick(8);
      chk("R6 start flag inside packet", desc_err, 1);

      finish_run();
   end
endmodule